// File: doc/BRIEF.md
# Gapless Link-Frame Packer

The packer sits between an event derandomizer and a fixed-width link. Once per clock it emits one link frame: an 80-bit payload and a 4-bit frame-kind code. It takes variable-length event records from a show-ahead FIFO read port, one record per cycle at most, and appends each one to a residual bit buffer. Frames are cut from the top of that buffer, MSB first. A record therefore starts at whatever bit position the previous record ended on, and it runs on into the next frame or frames when it does not fit.

A record is a 24-bit tag followed by its channel words. The tag carries a bunch-crossing number, the count of channel words and a 4-bit info field. While enough bits are pending, every frame is full of record data, with nothing inserted between records. When the FIFO runs dry with a partial frame pending, that remainder is flushed in a tail frame and the unused low bits carry the idle pattern. When nothing is pending, idle frames are sent. Serialization, line coding and error correction happen downstream.

Top module: `gapless_packer`

## Requirements
- R1: A record is sent MSB first as: crossing number (12 bits), channel count n (8 bits), info (4 bits), then channel words 0..n-1 of 5 bits each, channel 0 first. Its length is 24 + 5n bits. On the input bus, channel j sits at bits [(32-j)*5-1 -: 5], so channel 0 is at the top.
- R2: Every cycle one frame leaves, as `framePay` (80 bits) and `frameHdr`. The header codes are 4'h5 for a full data frame, 4'hA for a tail frame and 4'h0 for an idle frame. No other code appears.
- R3: Take the payload of every full frame, plus the used top part of every tail frame, in order. The result is the accepted records back-to-back, in the order they were popped, with no bit missing or added.
- R4: A record may begin at any bit position of a frame and continue into the following frame or frames.
- R5: `recPop` is high only while `recValid` is high. It is high exactly when the pending bits plus the offered record fit in the 264-bit residual buffer. At most one record is taken per cycle.
- R6: When the pending bits plus any record popped in a cycle reach 80 or more, the next frame, visible after the following clock edge, is a full frame holding the oldest 80 pending bits.
- R7: An idle frame carries the idle pattern: payload bit i equals i mod 2. An idle frame is sent when fewer than 80 bits are pending and either the FIFO is still offering data or nothing is pending.
- R8: When `recValid` is low and 1 to 79 bits are pending, a tail frame is sent. The pending bits are MSB-aligned, the remaining low bits follow the idle pattern, and the buffer is left empty, so two tail frames never follow each other.
- R9: During reset, `frameHdr` is idle, the payload is the idle pattern, and `recPop` stays low while `recValid` is low.
- R10: Input channel slots at or beyond the record's channel count are ignored. Their contents never reach the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz frame clock |
| rstN | input | 1 | Asynchronous reset, active low |
| recValid | input | 1 | FIFO holds a record on the input bus |
| recXid | input | 12 | Crossing number of the offered record |
| recSize | input | 8 | Channel word count of the offered record |
| recInfo | input | 4 | Info field of the offered record |
| recChans | input | MAX_CHANS*CHAN_W (160) | Channel words, channel 0 at the MSB end |
| recPop | output | 1 | Record accepted this cycle; FIFO advances |
| frameHdr | output | 4 | Frame kind code |
| framePay | output | FRAME_W (80) | Frame payload |

## Verification
The bench builds the packer with its defaults: an 80-bit frame, 5-bit channels and up to 32 channels per record. The longest record is then 184 bits, more than two frames. This makes three things reachable: a single record filling two full frames and a tail, two back-to-back maximum records overflowing the 264-bit residual so that the pop is refused for a cycle, and chains of 24-bit empty records too short to fill a frame, which force idle frames between full ones. Random lengths, random FIFO gaps and junk in the unused channel slots then exercise split positions, tail flushes and the ignoring of unused slots.

// File: rtl/gp_pkg.sv
`timescale 1ns/1ps
package gp_pkg;
  localparam int XID_W  = 12;
  localparam int SIZE_W = 8;
  localparam int INFO_W = 4;
  localparam int TAG_W  = XID_W + SIZE_W + INFO_W;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    FH_IDLE = 4'h0,
    FH_FULL = 4'h5,
    FH_TAIL = 4'hA
  } frameKind_e;

  typedef struct packed {
    logic pop;
    logic sendFull;
    logic sendTail;
    logic sendIdle;
  } packCmd_t;
endpackage

// File: rtl/gp_rec_build.sv
`timescale 1ns/1ps
module gp_rec_build
  import gp_pkg::*;
#(
  parameter int CHAN_W    = 5,
  parameter int MAX_CHANS = 32,
  localparam int CH_BITS  = MAX_CHANS * CHAN_W,
  localparam int REC_W    = TAG_W + CH_BITS,
  localparam int LEN_W    = $clog2(REC_W + 1)
) (
  input  logic [XID_W-1:0]  recXid,
  input  logic [SIZE_W-1:0] recSize,
  input  logic [INFO_W-1:0] recInfo,
  input  logic [CH_BITS-1:0] recChans,
  output logic [REC_W-1:0]  recBits,
  output logic [LEN_W-1:0]  recLen
);
  logic [CH_BITS-1:0] chanKeep;

  // slots past the count are forced to zero so they cannot leak into the stream
  for (genvar j = 0; j < MAX_CHANS; j++) begin : g_chan
    localparam int HI = (MAX_CHANS - j) * CHAN_W - 1;
    assign chanKeep[HI -: CHAN_W] =
      (recSize > SIZE_W'(j)) ? recChans[HI -: CHAN_W] : '0;
  end

  assign recBits = {recXid, recSize, recInfo, chanKeep};
  assign recLen  = LEN_W'(TAG_W) + LEN_W'(recSize) * LEN_W'(CHAN_W);
endmodule

// File: rtl/gp_ctrl.sv
`timescale 1ns/1ps
module gp_ctrl
  import gp_pkg::*;
#(
  parameter int FRAME_W = 80,
  parameter int RES_W   = 264,
  parameter int LEN_W   = 8,
  localparam int FILL_W = $clog2(RES_W + 1),
  localparam int SUM_W  = FILL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recValid,
  input  logic [LEN_W-1:0]  recLen,
  output packCmd_t          cmd,
  output logic [FILL_W-1:0] fillLvl
);
  logic [FILL_W-1:0] fillQ, fillNext;
  logic [SUM_W-1:0]  sumLen, combLen;

  always_comb begin
    cmd          = '0;
    sumLen       = SUM_W'(fillQ) + SUM_W'(recLen);
    cmd.pop      = recValid && (sumLen <= SUM_W'(RES_W));
    combLen      = cmd.pop ? sumLen : SUM_W'(fillQ);
    cmd.sendFull = combLen >= SUM_W'(FRAME_W);
    cmd.sendTail = !cmd.sendFull && !recValid && (fillQ != '0);
    cmd.sendIdle = !cmd.sendFull && !cmd.sendTail;
    if (cmd.sendFull)      fillNext = FILL_W'(combLen - SUM_W'(FRAME_W));
    else if (cmd.sendTail) fillNext = '0;
    else                   fillNext = FILL_W'(combLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fillQ <= '0;
    else       fillQ <= fillNext;
  end

  assign fillLvl = fillQ;
endmodule

// File: rtl/gp_data.sv
`timescale 1ns/1ps
module gp_data
  import gp_pkg::*;
#(
  parameter int FRAME_W = 80,
  parameter int REC_W   = 184,
  parameter int RES_W   = FRAME_W + REC_W,
  localparam int FILL_W = $clog2(RES_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  packCmd_t          cmd,
  input  logic [FILL_W-1:0] fillLvl,
  input  logic [REC_W-1:0]  recBits,
  output logic [KIND_W-1:0] frameHdr,
  output logic [FRAME_W-1:0] framePay
);
  function automatic logic [FRAME_W-1:0] mkIdle();
    logic [FRAME_W-1:0] v;
    for (int i = 0; i < FRAME_W; i++) v[i] = (i % 2) == 1;
    return v;
  endfunction

  localparam logic [FRAME_W-1:0] IDLE_PAT = mkIdle();

  logic [RES_W-1:0]   resQ, recWide, incoming, merged;
  logic [FRAME_W-1:0] topSlice, tailKeep, tailWord, payQ;
  frameKind_e         hdrQ;

  always_comb begin
    recWide  = {recBits, {(RES_W - REC_W){1'b0}}};
    incoming = cmd.pop ? (recWide >> fillLvl) : '0;
    merged   = resQ | incoming;
    topSlice = merged[RES_W-1 -: FRAME_W];
    tailKeep = ~({FRAME_W{1'b1}} >> fillLvl);
    tailWord = (topSlice & tailKeep) | (IDLE_PAT & ~tailKeep);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ <= '0;
      hdrQ <= FH_IDLE;
      payQ <= IDLE_PAT;
    end else if (cmd.sendFull) begin
      resQ <= merged << FRAME_W;
      hdrQ <= FH_FULL;
      payQ <= topSlice;
    end else if (cmd.sendTail) begin
      resQ <= '0;
      hdrQ <= FH_TAIL;
      payQ <= tailWord;
    end else if (cmd.sendIdle) begin
      resQ <= merged;
      hdrQ <= FH_IDLE;
      payQ <= IDLE_PAT;
    end
  end

  assign frameHdr = hdrQ;
  assign framePay = payQ;
endmodule

// File: rtl/gapless_packer.sv
`timescale 1ns/1ps
module gapless_packer
  import gp_pkg::*;
#(
  parameter int FRAME_W   = 80,
  parameter int CHAN_W    = 5,
  parameter int MAX_CHANS = 32,
  localparam int CH_BITS  = MAX_CHANS * CHAN_W,
  localparam int REC_W    = TAG_W + CH_BITS,
  localparam int RES_W    = FRAME_W + REC_W,
  localparam int LEN_W    = $clog2(REC_W + 1),
  localparam int FILL_W   = $clog2(RES_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               recValid,
  input  logic [11:0]        recXid,
  input  logic [7:0]         recSize,
  input  logic [3:0]         recInfo,
  input  logic [CH_BITS-1:0] recChans,
  output logic               recPop,
  output logic [3:0]         frameHdr,
  output logic [FRAME_W-1:0] framePay
);
  logic [REC_W-1:0]  recBits;
  logic [LEN_W-1:0]  recLen;
  logic [FILL_W-1:0] fillLvl;
  packCmd_t          cmd;

  gp_rec_build #(.CHAN_W(CHAN_W), .MAX_CHANS(MAX_CHANS)) uBuild (
    .recXid(recXid), .recSize(recSize), .recInfo(recInfo), .recChans(recChans),
    .recBits(recBits), .recLen(recLen)
  );

  gp_ctrl #(.FRAME_W(FRAME_W), .RES_W(RES_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .recValid(recValid), .recLen(recLen),
    .cmd(cmd), .fillLvl(fillLvl)
  );

  gp_data #(.FRAME_W(FRAME_W), .REC_W(REC_W), .RES_W(RES_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .fillLvl(fillLvl), .recBits(recBits),
    .frameHdr(frameHdr), .framePay(framePay)
  );

  assign recPop = cmd.pop;
endmodule

// File: rtl/gp_checker.sv
`timescale 1ns/1ps
module gp_checker #(
  parameter int FRAME_W = 80
) (
  input logic               clk,
  input logic               rstN,
  input logic               recValid,
  input logic               recPop,
  input logic [3:0]         frameHdr,
  input logic [FRAME_W-1:0] framePay
);
  function automatic logic [FRAME_W-1:0] oddOnes();
    logic [FRAME_W-1:0] v = '0;
    for (int i = 1; i < FRAME_W; i += 2) v[i] = 1'b1;
    return v;
  endfunction

  localparam logic [FRAME_W-1:0] EXP_IDLE = oddOnes();

  a_r2_legal_hdr: assert property (@(posedge clk) disable iff (!rstN)
    frameHdr == 4'h0 || frameHdr == 4'h5 || frameHdr == 4'hA);

  a_r5_pop_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    recPop |-> recValid);

  a_r7_idle_payload: assert property (@(posedge clk) disable iff (!rstN)
    frameHdr == 4'h0 |-> framePay == EXP_IDLE);

  a_r8_tail_after_empty: assert property (@(posedge clk) disable iff (!rstN)
    frameHdr == 4'hA |-> $past(!recValid));

  a_r8_single_tail: assert property (@(posedge clk) disable iff (!rstN)
    frameHdr == 4'hA |=> frameHdr != 4'hA);
endmodule

bind gapless_packer gp_checker #(.FRAME_W(FRAME_W)) uChk (
  .clk(clk), .rstN(rstN), .recValid(recValid), .recPop(recPop),
  .frameHdr(frameHdr), .framePay(framePay)
);

// File: tb/gapless_packer_test.sv
`timescale 1ns/1ps
module gapless_packer_test;
  localparam int FRAME_W = 80, CHAN_W = 5, MAX_CHANS = 32;
  localparam int CH_BITS = MAX_CHANS * CHAN_W;

  typedef struct packed {
    logic [11:0]        xid;
    logic [7:0]         size;
    logic [3:0]         info;
    logic [CH_BITS-1:0] chans;
  } rec_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, recValid = 1'b0, recPop;
  logic [11:0] recXid = '0;
  logic [7:0] recSize = '0;
  logic [3:0] recInfo = '0, frameHdr;
  logic [CH_BITS-1:0] recChans = '0;
  logic [FRAME_W-1:0] framePay;

  gapless_packer #(.FRAME_W(FRAME_W), .CHAN_W(CHAN_W), .MAX_CHANS(MAX_CHANS)) uut (
    .clk(clk), .rstN(rstN), .recValid(recValid), .recXid(recXid), .recSize(recSize),
    .recInfo(recInfo), .recChans(recChans), .recPop(recPop),
    .frameHdr(frameHdr), .framePay(framePay)
  );

  rec_t fifoQ[$];
  rec_t expQ[$];
  bit   streamQ[$];
  int   checks = 0, fails = 0, splitCount = 0;
  bit   gateOpen = 1'b1, popNow = 1'b0;
  logic [3:0] lastHdr = '0;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic bit idleBit(input int i);
    return (i % 2) == 1;
  endfunction

  function automatic logic [31:0] takeBits(input int w);
    logic [31:0] v = '0;
    for (int i = 0; i < w; i++) v = {v[30:0], streamQ.pop_front()};
    return v;
  endfunction

  // R3: rebuild records from the bit stream and compare with the order of entry
  task automatic parseStream();
    while (streamQ.size() >= 24) begin
      int n = 0;
      rec_t e;
      logic [11:0] gx; logic [7:0] gs; logic [3:0] gi;
      bit same;
      for (int k = 0; k < 8; k++) n = n * 2 + int'(streamQ[12 + k]);
      if (streamQ.size() < 24 + n * CHAN_W) break;
      gx = 12'(takeBits(12)); gs = 8'(takeBits(8)); gi = 4'(takeBits(4));
      if (expQ.size() == 0) begin
        check(1'b0, $sformatf("R3 unexpected record act xid=%h exp none", gx));
        for (int j = 0; j < n; j++) void'(takeBits(CHAN_W));
      end else begin
        e = expQ.pop_front();
        same = (gx == e.xid) && (gs == e.size) && (gi == e.info);
        for (int j = 0; j < n; j++) begin
          logic [4:0] gc = 5'(takeBits(CHAN_W));
          if (gc != e.chans[(MAX_CHANS - j) * CHAN_W - 1 -: CHAN_W]) same = 1'b0;
        end
        check(same, $sformatf("R3/R1/R10 record act xid=%h size=%0d info=%h exp xid=%h size=%0d info=%h",
                              gx, gs, gi, e.xid, e.size, e.info));
      end
    end
  endtask

  task automatic monitor();
    lastHdr = frameHdr;
    case (frameHdr)
      4'h5: begin
        if (streamQ.size() > 0) splitCount++;
        for (int i = FRAME_W - 1; i >= 0; i--) streamQ.push_back(framePay[i]);
        parseStream();
      end
      4'hA: begin
        int l;
        bit padOk = 1'b1;
        for (int i = FRAME_W - 1; i >= 0; i--) streamQ.push_back(framePay[i]);
        parseStream();
        l = streamQ.size();
        for (int i = 0; i < l; i++) if (framePay[i] != idleBit(i)) padOk = 1'b0;
        check(padOk && l >= 1 && l < FRAME_W,
              $sformatf("R8 tail padding act len=%0d ok=%0d exp len 1..79 ok=1", l, padOk));
        streamQ.delete();
      end
      4'h0: begin
        bit patOk = 1'b1;
        for (int i = 0; i < FRAME_W; i++) if (framePay[i] != idleBit(i)) patOk = 1'b0;
        check(patOk, $sformatf("R7 idle payload act %h", framePay));
      end
      default: check(1'b0, $sformatf("R2 header code act %h exp 0/5/A", frameHdr));
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    monitor();
    if (fifoQ.size() > 0 && gateOpen) begin
      recValid = 1'b1;
      recXid   = fifoQ[0].xid;
      recSize  = fifoQ[0].size;
      recInfo  = fifoQ[0].info;
      recChans = fifoQ[0].chans;
    end else begin
      recValid = 1'b0;
      recChans = {CH_BITS{1'b1}};
    end
    #1;
    popNow = recPop;
    if (popNow) begin
      if (!recValid) check(1'b0, "R5 pop without valid act 1 exp 0");
      else void'(fifoQ.pop_front());
    end
  endtask

  task automatic pushRec(input int n, input bit junk);
    rec_t r;
    r.xid  = 12'($urandom);
    r.size = 8'(n);
    r.info = 4'($urandom);
    for (int j = 0; j < MAX_CHANS; j++)
      r.chans[(MAX_CHANS - j) * CHAN_W - 1 -: CHAN_W] =
        (j < n || junk) ? 5'($urandom) : 5'd0;
    fifoQ.push_back(r);
    expQ.push_back(r);
  endtask

  task automatic drain();
    gateOpen = 1'b1;
    while (fifoQ.size() > 0) step();
    repeat (6) step();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog act running exp finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rec_t big;
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check(frameHdr == 4'h0 && recPop == 1'b0,
            $sformatf("R9 reset act hdr=%h pop=%b exp hdr=0 pop=0", frameHdr, recPop));
      check(framePay == {40{2'b10}}, $sformatf("R9 reset payload act %h", framePay));
    end
    rstN = 1'b1;
    repeat (2) step();

    // R6/R8/R1: one 184-bit record -> full, full, tail, idle
    pushRec(32, 1'b0);
    big = fifoQ[0];
    step();
    check(popNow, $sformatf("R5 pop into empty buffer act %b exp 1", popNow));
    step();
    check(lastHdr == 4'h5, $sformatf("R6 first frame act %h exp 5", lastHdr));
    check(framePay[79:68] == big.xid && framePay[67:60] == 8'd32 &&
          framePay[59:56] == big.info &&
          framePay[55:51] == big.chans[CH_BITS-1 -: CHAN_W],
          $sformatf("R1 tag layout act %h exp xid=%h info=%h", framePay[79:51], big.xid, big.info));
    step();
    check(lastHdr == 4'h5, $sformatf("R6 second frame act %h exp 5", lastHdr));
    step();
    check(lastHdr == 4'hA, $sformatf("R8 third frame act %h exp A", lastHdr));
    step();
    check(lastHdr == 4'h0, $sformatf("R7 after tail act %h exp 0", lastHdr));

    // R5: two maximum records overflow the residual for one cycle
    pushRec(32, 1'b0);
    pushRec(32, 1'b0);
    step();
    check(popNow, $sformatf("R5 first max pop act %b exp 1", popNow));
    step();
    check(!popNow && recValid, $sformatf("R5 refused pop act pop=%b valid=%b exp 0/1", popNow, recValid));
    step();
    check(popNow, $sformatf("R5 second max pop act %b exp 1", popNow));
    drain();

    // R7: chain of empty records, 24 bits per cycle, idle frames in between
    repeat (10) pushRec(0, 1'b0);
    drain();

    // R10: junk in unused channel slots
    for (int k = 0; k < 20; k++) pushRec(int'($urandom_range(0, MAX_CHANS)), 1'b1);
    drain();

    // R3/R4: random lengths with random FIFO gaps
    for (int k = 0; k < 300; k++) pushRec(int'($urandom_range(0, MAX_CHANS)), k % 3 == 0);
    while (fifoQ.size() > 0) begin
      gateOpen = ($urandom_range(0, 3) != 0);
      step();
    end
    drain();

    check(expQ.size() == 0 && streamQ.size() == 0,
          $sformatf("R3 leftover act records=%0d bits=%0d exp 0/0", expQ.size(), streamQ.size()));
    check(splitCount > 0, $sformatf("R4 straddling records act %0d exp >0", splitCount));
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule